// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit with Condition Codes

This unit is the arithmetic and logic stage of a small processor datapath. It takes two operand words, X and Y, and a two-bit function code. It returns one result word and three condition codes: signed overflow, zero and carry. The function code chooses the result from four operations: addition, subtraction (X minus Y), bitwise AND and bitwise XOR.

The unit holds no state and takes no clock. The result and the three codes follow the operands and the function code continuously. A downstream condition-code register decides whether to latch the codes. An adder shared by both arithmetic operations produces the sum or the difference together with its carry and overflow. A bitwise unit produces the two logical results, and a flag stage derives the condition codes from whichever result is selected.

Top module: `cc_alu`

## Requirements
- R1: Function code 2'd0 drives the result with X + Y, modulo 2^WIDTH.
- R2: Function code 2'd1 drives the result with X - Y (Y taken from X, not the reverse), modulo 2^WIDTH.
- R3: Function code 2'd2 drives the result with the bitwise AND of X and Y.
- R4: Function code 2'd3 drives the result with the bitwise XOR of X and Y.
- R5: The unit has no clock or storage; a change on any input shows on the outputs in the same cycle, with no register in the path.
- R6: The zero flag is 1 exactly when every bit of the selected result is 0, for all four function codes.
- R7: For the two logical codes (2'd2 and 2'd3), the overflow and carry flags are both 0.
- R8: For code 2'd0, carry is the carry out of the top bit of the unsigned sum.
- R9: For code 2'd1, carry is the borrow: 1 exactly when X is less than Y as unsigned numbers.
- R10: For code 2'd0, overflow is 1 exactly when X and Y have the same top bit and the result's top bit differs from it.
- R11: For code 2'd1, overflow is 1 exactly when X and Y differ in their top bit and the result's top bit differs from X's.
- R12: The operand and result width is the parameter WIDTH, 32 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand X |
| opb_i | input | WIDTH | Operand Y |
| func_i | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| result_o | output | WIDTH | Selected result |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out on add, borrow on subtract |

## Verification
The zero flag can be set in the same cycle as carry or overflow, and this is where a flag stage that looks at the wrong word would show. The bench forces these pairs directly. It adds 0x80000000 to itself, which gives a zero result with both carry and overflow. It adds 0xFFFFFFFF to 1, which gives a zero result with carry but no overflow. It subtracts an operand from itself, which gives a zero result with neither carry nor overflow. For each case, all four outputs are compared in the same cycle against a reference model that the bench computes from the requirements.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic carry;
  } alu_cc_t;

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;

  // Subtraction is a + ~b + 1; the carry-in comes from sub_i
  assign b_eff    = sub_i ? ~b_i : b_i;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o    = wide_sum[MSB:0];

  // On subtract, a borrow is the inverted carry out
  assign carry_o  = wide_sum[WIDTH] ^ sub_i;

  // Same-sign addends with a result of the other sign
  assign ovf_o    = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/cc_alu_bitwise.sv
module cc_alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_xor_i,
  output logic [WIDTH-1:0] res_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign res_o[i] = sel_xor_i ? (a_i[i] ^ b_i[i]) : (a_i[i] & b_i[i]);
  end

endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             arith_i,
  input  logic             ar_carry_i,
  input  logic             ar_ovf_i,
  output alu_cc_t          cc_o
);

  always_comb begin
    cc_o.zero  = (result_i == '0);
    cc_o.carry = arith_i & ar_carry_i;
    cc_o.ovf   = arith_i & ar_ovf_i;
  end

endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [1:0]       func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o,
  output logic             zero_o,
  output logic             carry_o
);

  alu_fn_e          fn;
  logic             is_arith;
  logic [WIDTH-1:0] ar_res;
  logic [WIDTH-1:0] lg_res;
  logic             ar_carry;
  logic             ar_ovf;
  alu_cc_t          cc;

  assign fn       = alu_fn_e'(func_i);
  assign is_arith = (fn == FN_ADD) || (fn == FN_SUB);

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sub_i   (fn == FN_SUB),
    .sum_o   (ar_res),
    .carry_o (ar_carry),
    .ovf_o   (ar_ovf)
  );

  cc_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i       (opa_i),
    .b_i       (opb_i),
    .sel_xor_i (fn == FN_XOR),
    .res_o     (lg_res)
  );

  assign result_o = is_arith ? ar_res : lg_res;

  cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i   (result_o),
    .arith_i    (is_arith),
    .ar_carry_i (ar_carry),
    .ar_ovf_i   (ar_ovf),
    .cc_o       (cc)
  );

  assign ovf_o   = cc.ovf;
  assign zero_o  = cc.zero;
  assign carry_o = cc.carry;

endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [1:0]       func_i,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o,
  input logic             zero_o,
  input logic             carry_o
);

  always_comb begin
    if (func_i == 2'd0)
      AST_ADD_UNDO: assert (result_o - opb_i == opa_i);                        // R1
    if (func_i == 2'd1)
      AST_SUB_UNDO: assert (result_o + opb_i == opa_i);                        // R2
    if (func_i == 2'd2)
      AST_AND_SUBSET: assert (((result_o & ~opa_i) | (result_o & ~opb_i)) == '0); // R3
    if (func_i == 2'd3)
      AST_XOR_UNDO: assert ((result_o ^ opb_i) == opa_i);                      // R4
    if (zero_o)
      AST_ZERO_EMPTY: assert ($countones(result_o) == 0);                      // R6
    if (func_i[1])
      AST_LOGIC_QUIET: assert (!ovf_o && !carry_o);                            // R7
    if (func_i == 2'd0)
      AST_ADD_WRAP: assert (carry_o == (result_o < opa_i));                    // R8
    if (func_i == 2'd1)
      AST_SUB_BORROW: assert (carry_o == (opa_i < opb_i));                     // R9
  end

endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .func_i   (func_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o),
  .carry_o  (carry_o)
);

// File: tb/tb_cc_alu.sv
module tb_cc_alu;

  localparam int W = 32;
  localparam int WATCHDOG = 20000;

  typedef struct {
    logic [W-1:0] res;
    logic         ovf;
    logic         zero;
    logic         carry;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [1:0]   f = 2'd2;
  logic [W-1:0] res;
  logic         ovf, zero, carry;

  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;
  bit   dog_hit = 0;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  cc_alu #(.WIDTH(W)) dut (
    .opa_i(x), .opb_i(y), .func_i(f),
    .result_o(res), .ovf_o(ovf), .zero_o(zero), .carry_o(carry)
  );

  // Reference model written from the requirements
  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] fn, string req);
    exp_t e;
    logic [W:0] wide;
    e.ovf = 1'b0; e.carry = 1'b0; e.req = req;
    case (fn)
      2'd0: begin
        wide    = {1'b0, a} + {1'b0, b};
        e.res   = wide[W-1:0];
        e.carry = wide[W];                                               // R8
        e.ovf   = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);          // R10
      end
      2'd1: begin
        e.res   = a - b;
        e.carry = (a < b);                                               // R9
        e.ovf   = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);          // R11
      end
      2'd2: e.res = a & b;                                               // R3
      default: e.res = a ^ b;                                            // R4
    endcase
    e.zero = (e.res == '0);                                              // R6
    return e;
  endfunction

  // Driver: inputs change at the rising edge, expectation queued
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] fn, string req);
    @(posedge clk);
    x <= a; y <= b; f <= fn;
    sb.push_back(model(a, b, fn, req));
  endtask

  // Monitor: same-cycle comparison at the falling edge (R5: no register in path)
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (res !== e.res || ovf !== e.ovf || zero !== e.zero || carry !== e.carry) begin
          n_bad++;
          $display("FAIL %s: got res=%h ovf=%b zero=%b carry=%b, expected res=%h ovf=%b zero=%b carry=%b",
                   e.req, res, ovf, zero, carry, e.res, e.ovf, e.zero, e.carry);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      dog_hit = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // Idle state: AND of zeros, R6 zero set, R7 flags clear
    drive('0, '0, 2'd2, "R6");
    // R1 / R10 / R8 plain sums and overflow
    drive(32'd5, 32'd7, 2'd0, "R1");
    drive(32'h7FFF_FFFF, 32'd1, 2'd0, "R10");
    drive(32'h8000_0000, 32'hFFFF_FFFF, 2'd0, "R10");
    drive(32'hFFFF_FFFF, 32'd1, 2'd0, "R8");         // zero + carry, no ovf
    drive(32'h8000_0000, 32'h8000_0000, 2'd0, "R8"); // zero + carry + ovf
    // R2 / R9 / R11 operand order, borrow, overflow
    drive(32'd3, 32'd10, 2'd1, "R2");
    drive(32'd10, 32'd3, 2'd1, "R2");
    drive(32'd0, 32'd1, 2'd1, "R9");
    drive(32'h8000_0000, 32'd1, 2'd1, "R11");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1, "R11");
    drive(32'h1234_5678, 32'h1234_5678, 2'd1, "R6"); // zero, no flags
    // R3 / R4 / R7 logical codes
    drive(32'hF0F0_F0F0, 32'h0FF0_0FF0, 2'd2, "R3");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 2'd2, "R6");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, "R4");
    drive(32'hFFFF_FFFF, 32'h8000_0000, 2'd3, "R7");
    // R5: inputs change every cycle with no pipeline delay; R12 full width
    for (int i = 0; i < 800; i++) begin
      logic [W-1:0] a, b;
      logic [1:0]   fn;
      a  = $urandom();
      b  = (i % 7 == 0) ? a : $urandom();
      fn = 2'(i % 4);
      case (fn)
        2'd0: drive(a, b, fn, "R1");
        2'd1: drive(a, b, fn, "R2");
        2'd2: drive(a, b, fn, "R3");
        default: drive(a, b, fn, "R4");
      endcase
    end
    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    done = 1;
  end

  initial begin
    wait (done || dog_hit);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule